// File: doc/BRIEF.md
# Multiplexed SAR ADC Control Sequencer

This block is the digital control section of an eight-channel successive-approximation acquisition front end. A host drives three asynchronous strobes: a read/convert line (low requests a conversion, high requests a read), a chip enable, and a channel-address latch strobe with a 3-bit address. The block synchronises these strobes and holds the selected channel. It starts one conversion each time the convert condition becomes true, then times a fixed settling/acquisition window. After that it runs a most-significant-bit-first successive-approximation loop against a one-bit comparator input.

While a conversion runs, a busy flag stays high. The finished code is committed to an output register a set number of cycles before busy falls. The 12-bit result bus has a separate output-enable, which a pad ring uses for tri-stating. The multiplexer, track-and-hold, DAC and comparator sit outside the block. The trial code on `dac_o` feeds the external DAC, and `cmp_i` returns the comparison.

Top module: `sar_das_ctrl`

## Requirements
- R1: A conversion starts when the synchronised read/convert line is low and the synchronised chip enable is high together. Busy is seen high on the third clock edge after the input change that completes this condition (two synchroniser flops plus one state flop).
- R2: Whichever of the two lines reaches its active level last acts as the trigger. This holds with chip enable raised first, with read/convert lowered first, and with both changed in the same cycle.
- R3: While chip enable is low, no conversion starts, however long read/convert stays low. The output-enable also stays low.
- R4: Once started, a conversion cannot be restarted or aborted. Busy stays high for exactly ACQ_CYCLES + NBITS + COMMIT_LEAD cycles, even if read/convert toggles during it. No new conversion follows unless the convert condition is removed and then reasserted.
- R5: At each start the approximation register is cleared, so `dac_o` reads 0 during acquisition. The first trial after acquisition is the MSB alone (bit 11 = 0x800). Then one bit is resolved per cycle, from MSB to LSB. Each trial bit is kept when `cmp_i` is 1, meaning the input is at or above the trial code.
- R6: The committed result is the straight-binary code of the selected input, with bit 11 as the MSB. For an ideal comparator it equals the target code.
- R7: The result register is loaded exactly COMMIT_LEAD cycles before busy falls. It never changes while busy is low.
- R8: The channel address is captured on the falling edge of the synchronised latch strobe. At all other times, including when the address lines change during a conversion, `chan_o` holds its value.
- R9: `data_oe_o` is high only when read/convert is high, chip enable is high and busy is low. It is low whenever read/convert is low.
- R10: After reset, busy, output-enable, result and channel are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_n_i | input | 1 | Read/convert strobe: low = convert, high = read (asynchronous) |
| ce_i | input | 1 | Chip enable, active high (asynchronous) |
| latch_i | input | 1 | Channel-address latch strobe, captures on falling edge (asynchronous) |
| addr_i | input | 3 | Channel address |
| cmp_i | input | 1 | Comparator: 1 when the analog input is at or above `dac_o` |
| dac_o | output | 12 | Trial code to the external DAC |
| chan_o | output | 3 | Latched channel select to the multiplexer |
| busy_o | output | 1 | Conversion in progress |
| data_o | output | 12 | Result register, straight binary |
| data_oe_o | output | 1 | Drive enable for the result bus pads |

## Verification
Several faults show at the ports in specific ways. A wrong sequencer state or counter shows up as a busy pulse of the wrong length, counted cycle by cycle against the parameter sum. It also shows up as a result that appears at the wrong distance from busy falling. A fault in the approximation register shows within the first conversion cycle: `dac_o` is non-zero during acquisition, or the first trial is not the lone MSB. Such a fault also ends as a committed code that differs from the comparator target, visible once busy drops. A faulty start edge detector or channel latch shows as a second busy pulse after a mid-conversion strobe toggle, or as a changed `chan_o` after address lines move without a latch strobe. Both appear within a few cycles of the stimulus.

// File: rtl/sar_das_pkg.sv
`timescale 1ns/1ps
package sar_das_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACQ  = 2'd1,
        SEQ_SAR  = 2'd2,
        SEQ_HOLD = 2'd3
    } seq_state_e;

endpackage

// File: rtl/das_sync.sv
`timescale 1ns/1ps
module das_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/das_chan_latch.sv
`timescale 1ns/1ps
module das_chan_latch #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_s,
    input  logic [AW-1:0] addr_s,
    output logic [AW-1:0] chan_o,
    output logic          fall_o
);

    typedef struct packed {
        logic          strobe_prev;
        logic [AW-1:0] chan;
    } latch_reg_t;

    latch_reg_t lat_d, lat_q;

    always_comb begin
        lat_d             = lat_q;
        lat_d.strobe_prev = strobe_s;
        fall_o            = lat_q.strobe_prev & ~strobe_s;
        if (fall_o) lat_d.chan = addr_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign chan_o = lat_q.chan;

endmodule

// File: rtl/das_sar_core.sv
`timescale 1ns/1ps
module das_sar_core #(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic             cmp_i,
    output logic [NBITS-1:0] trial_o,
    output logic [NBITS-1:0] code_o,
    output logic [NBITS-1:0] result_o,
    output logic             last_o
);

    localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;

    typedef struct packed {
        logic [NBITS-1:0] sar;
        logic [IW-1:0]    idx;
    } sar_reg_t;

    sar_reg_t sar_d, sar_q;
    logic [NBITS-1:0] mask;

    always_comb begin
        mask     = {{(NBITS-1){1'b0}}, 1'b1} << sar_q.idx;
        trial_o  = sar_q.sar | mask;
        sar_d    = sar_q;
        last_o   = 1'b0;
        result_o = sar_q.sar;
        if (clr_i) begin
            sar_d.sar = '0;
            sar_d.idx = IW'(NBITS-1);
        end else if (step_i) begin
            sar_d.sar = cmp_i ? (sar_q.sar | mask) : (sar_q.sar & ~mask);
            result_o  = sar_d.sar;
            if (sar_q.idx == '0) last_o = 1'b1;
            else                 sar_d.idx = sar_q.idx - IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q.sar <= '0;
            sar_q.idx <= IW'(NBITS-1);
        end else begin
            sar_q <= sar_d;
        end
    end

    assign code_o = sar_q.sar;

endmodule

// File: rtl/sar_das_ctrl.sv
`timescale 1ns/1ps
module sar_das_ctrl #(
    parameter int NBITS       = 12,
    parameter int NCHAN       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ACQ_CYCLES  = 19,
    parameter int COMMIT_LEAD = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rc_n_i,
    input  logic                     ce_i,
    input  logic                     latch_i,
    input  logic [$clog2(NCHAN)-1:0] addr_i,
    input  logic                     cmp_i,
    output logic [NBITS-1:0]         dac_o,
    output logic [$clog2(NCHAN)-1:0] chan_o,
    output logic                     busy_o,
    output logic [NBITS-1:0]         data_o,
    output logic                     data_oe_o
);
    import sar_das_pkg::*;

    localparam int AW      = $clog2(NCHAN);
    localparam int SW      = AW + 3;
    localparam int CNT_MAX = (ACQ_CYCLES > COMMIT_LEAD) ? ACQ_CYCLES : COMMIT_LEAD;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b0, {AW{1'b0}}};

    logic [SW-1:0]    sync_s;
    logic             rc_n_s, ce_s, latch_s;
    logic [AW-1:0]    addr_s;
    logic             latch_fall;
    logic             conv_ok, start;
    logic             sar_clr, sar_step, sar_last;
    logic [NBITS-1:0] sar_trial, sar_code, sar_result;

    das_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({rc_n_i, ce_i, latch_i, addr_i}),
        .sync_o  (sync_s)
    );
    assign {rc_n_s, ce_s, latch_s, addr_s} = sync_s;

    das_chan_latch #(.AW(AW)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_s (latch_s),
        .addr_s   (addr_s),
        .chan_o   (chan_o),
        .fall_o   (latch_fall)
    );

    das_sar_core #(.NBITS(NBITS)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (sar_clr),
        .step_i   (sar_step),
        .cmp_i    (cmp_i),
        .trial_o  (sar_trial),
        .code_o   (sar_code),
        .result_o (sar_result),
        .last_o   (sar_last)
    );

    typedef struct packed {
        seq_state_e       state;
        logic [CW-1:0]    cnt;
        logic             conv_prev;
        logic [NBITS-1:0] data;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d           = seq_q;
        conv_ok         = ~rc_n_s & ce_s;
        seq_d.conv_prev = conv_ok;
        start           = conv_ok & ~seq_q.conv_prev & (seq_q.state == SEQ_IDLE);
        sar_clr         = 1'b0;
        sar_step        = 1'b0;
        case (seq_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    sar_clr     = 1'b1;
                    seq_d.state = SEQ_ACQ;
                    seq_d.cnt   = CW'(ACQ_CYCLES - 1);
                end
            end
            SEQ_ACQ: begin
                if (seq_q.cnt == '0) seq_d.state = SEQ_SAR;
                else                 seq_d.cnt   = seq_q.cnt - CW'(1);
            end
            SEQ_SAR: begin
                sar_step = 1'b1;
                if (sar_last) begin
                    seq_d.state = SEQ_HOLD;
                    seq_d.cnt   = CW'(COMMIT_LEAD - 1);
                    seq_d.data  = sar_result;
                end
            end
            SEQ_HOLD: begin
                if (seq_q.cnt == '0) seq_d.state = SEQ_IDLE;
                else                 seq_d.cnt   = seq_q.cnt - CW'(1);
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state     <= SEQ_IDLE;
            seq_q.cnt       <= '0;
            seq_q.conv_prev <= 1'b0;
            seq_q.data      <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o    = (seq_q.state != SEQ_IDLE);
    assign dac_o     = (seq_q.state == SEQ_SAR) ? sar_trial : sar_code;
    assign data_o    = seq_q.data;
    assign data_oe_o = rc_n_s & ce_s & ~busy_o;

endmodule

// File: rtl/sar_das_ctrl_chk.sv
`timescale 1ns/1ps
module sar_das_ctrl_chk #(
    parameter int NBITS = 12,
    parameter int AW    = 3,
    parameter int TOTAL = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rc_n_i,
    input logic             ce_i,
    input logic             busy_o,
    input logic             data_oe_o,
    input logic [NBITS-1:0] dac_o,
    input logic [NBITS-1:0] data_o,
    input logic [AW-1:0]    chan_o,
    input logic             latch_fall
);

    localparam int RW = $clog2(TOTAL + 2);
    logic [RW-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_run <= '0;
        else if (busy_o) busy_run <= busy_run + RW'(1);
        else             busy_run <= '0;
    end

    AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> ($past(rc_n_i, 2) && $past(ce_i, 2))); // R9

    AST_OE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !data_oe_o); // R9

    AST_SAR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (dac_o == '0)); // R5

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_run == RW'(TOTAL))); // R4

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RW'(TOTAL)); // R4

    AST_DATA_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(data_o)); // R7

    AST_CHAN_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_o) |-> $past(latch_fall)); // R8

endmodule

bind sar_das_ctrl sar_das_ctrl_chk #(
    .NBITS (NBITS),
    .AW    (AW),
    .TOTAL (ACQ_CYCLES + NBITS + COMMIT_LEAD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rc_n_i     (rc_n_i),
    .ce_i       (ce_i),
    .busy_o     (busy_o),
    .data_oe_o  (data_oe_o),
    .dac_o      (dac_o),
    .data_o     (data_o),
    .chan_o     (chan_o),
    .latch_fall (latch_fall)
);

// File: tb/sar_das_ctrl_test.sv
`timescale 1ns/1ps
module sar_das_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NBITS      = 12;
    localparam int ACQ        = 19;
    localparam int LEAD       = 5;
    localparam int TOTAL      = ACQ + NBITS + LEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rc_n = 1'b1;
    logic        ce = 1'b0;
    logic        latch = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic        cmp;
    logic [11:0] dac, data;
    logic [2:0]  chan;
    logic        busy, oe;

    logic [11:0] tgt [8];
    logic [11:0] prev_data = 12'd0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Ideal comparator: input at or above trial code gives 1
    assign cmp = (tgt[chan] >= dac);

    sar_das_ctrl #(.ACQ_CYCLES(ACQ), .COMMIT_LEAD(LEAD)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rc_n_i    (rc_n),
        .ce_i      (ce),
        .latch_i   (latch),
        .addr_i    (addr),
        .cmp_i     (cmp),
        .dac_o     (dac),
        .chan_o    (chan),
        .busy_o    (busy),
        .data_o    (data),
        .data_oe_o (oe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        cyc(1);
        check("R10 busy", busy, 0);
        check("R10 oe", oe, 0);
        check("R10 data", data, 0);
        check("R10 chan", chan, 0);
    endtask

    task automatic t_latch(input logic [2:0] ch);
        addr = ch; latch = 1'b1;
        cyc(3);
        latch = 1'b0;
        cyc(4);
        check("R8 capture", chan, ch);
        addr = ~ch;
        cyc(4);
        check("R8 hold without strobe", chan, ch);
    endtask

    // mode 0: ce first then rc low; 1: rc low first then ce high; 2: simultaneous
    task automatic t_convert(input int mode, input logic [2:0] ch, input bit toggle);
        rc_n = 1'b1;
        ce   = (mode == 0);
        cyc(4);
        if (mode == 1) begin
            rc_n = 1'b0;
            cyc(8);
            check("R3 no start with ce low", busy, 0);
            check("R3 no read with ce low", oe, 0);
            ce = 1'b1;
        end else if (mode == 2) begin
            rc_n = 1'b0; ce = 1'b1;
        end else begin
            rc_n = 1'b0;
        end
        cyc(2);
        check("R1 busy not yet", busy, 0);
        cyc(1);
        check("R2 busy after trigger", busy, 1);
        check("R5 sar cleared", dac, 0);
        addr = ~ch;
        for (int n = 2; n <= TOTAL + 1; n++) begin
            cyc(1);
            if (toggle && n == ACQ + 3) rc_n = 1'b1;
            if (toggle && n == ACQ + 6) rc_n = 1'b0;
            if (n == ACQ + 1)  check("R5 msb trial", dac, 12'h800);
            if (n == ACQ + 12) check("R7 data before commit", data, prev_data);
            if (n == ACQ + 13) check("R7 data committed", data, tgt[ch]);
            if (n == TOTAL)    check("R4 busy held", busy, 1);
            if (n == TOTAL + 1) check("R4 busy dropped", busy, 0);
        end
        check("R8 chan during conversion", chan, ch);
        cyc(8);
        check("R4 no rerun", busy, 0);
        check("R9 bus released rc low", oe, 0);
        rc_n = 1'b1;
        cyc(3);
        check("R9 bus driven on read", oe, 1);
        check("R6 result code", data, tgt[ch]);
        ce = 1'b0;
        cyc(3);
        check("R3 read blocked", oe, 0);
        check("R7 data stable idle", data, tgt[ch]);
        prev_data = tgt[ch];
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        tgt[0] = 12'hFFF; tgt[1] = 12'h123; tgt[2] = 12'h456; tgt[3] = 12'hA5C;
        tgt[4] = 12'h800; tgt[5] = 12'h001; tgt[6] = 12'h3C3; tgt[7] = 12'h7FF;
        cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_latch(3'd3);
        t_convert(0, 3'd3, 1'b0);
        t_latch(3'd0);
        t_convert(1, 3'd0, 1'b0);
        t_latch(3'd5);
        t_convert(2, 3'd5, 1'b0);
        t_latch(3'd7);
        t_convert(0, 3'd7, 1'b1);
        t_latch(3'd4);
        t_convert(2, 3'd4, 1'b1);
        done = 1'b1;
        finish_run();
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule